// File: doc/BRIEF.md
# Multiprocessor-Mode Asynchronous Serial Channel

This block is a single asynchronous serial channel with its own transmit and receive shifters, steered by one 8-bit control register. The register holds the transmitter and receiver enables, a request-to-send output bit, a wake-up enable, three frame-format bits, and a shared bit that reads back the last received multiprocessor bit and clears the error flags when written with 0. A separate input selects multiprocessor framing. In that framing every frame carries an extra bit after the data bits, used to tell address frames from data frames.

When multiprocessor framing and wake-up are both on, a filter in front of the flag logic passes only frames whose extra bit is 1. Other frames are dropped before they can touch the receive-full flag, the data register or the error flags. This lets many nodes share one line: each node sleeps through other nodes' traffic until an address frame arrives. The block is clocked by the system clock. Serial timing comes from a 16x oversampling tick supplied by an external baud generator.

Top module: `mpuart_chan`

## Requirements
- R1: After reset the control register reads 0x00 except bit 3 (wake-up enable bit 7, receiver enable bit 6, transmitter enable bit 5 and request-to-send bit 4 are all 0), the status register reads 0x20 (transmit-empty set, all other flags 0), tx_o is 1 and rts_o is 0.
- R2: A transmitted frame is one start bit (0), then 7 data bits (control bit 2 = 0) or 8 data bits (bit 2 = 1) LSB first, then one extra bit when multiprocessor framing is on or parity is on (bit 1 = 1), then one stop bit (bit 0 = 0) or two stop bits (bit 0 = 1) at level 1. Each bit lasts 16 ticks. The extra bit is status bit 7 in multiprocessor framing, and otherwise even parity over the data bits.
- R3: The receiver samples each bit at mid-bit. A completed accepted frame sets the receive-full flag (status bit 6), and its data reads at address 3 with bit 7 forced to 0 in 7-bit mode. Reading address 3 clears receive-full. With the receiver enable at 0, incoming frames change nothing.
- R4: With multiprocessor framing off, every received frame updates the flags and data register, whatever the wake-up enable holds.
- R5: With multiprocessor framing and wake-up both on, a frame whose extra bit is 0 leaves receive-full, data and all error flags unchanged, and a frame whose extra bit is 1 is accepted.
- R6: With multiprocessor framing on and wake-up off, every frame is accepted, whatever its extra bit.
- R7: In multiprocessor framing, control bit 3 reads the extra bit of the most recently completed frame, whether or not the frame was accepted. With multiprocessor framing off, it reads 0.
- R8: Writing the control register with bit 3 = 0 clears overrun (status bit 4), framing (bit 3), parity (bit 2) and break (bit 1). Writing it with bit 3 = 1 leaves them as they are.
- R9: On an accepted frame, a 0 in the first stop bit sets framing error. An extra bit that differs from even parity sets parity error, but only when parity is on and multiprocessor framing is off. A frame whose every bit, stop bit included, is 0 sets break.
- R10: An accepted frame that completes while receive-full is set sets overrun and does not replace the held data.
- R11: Clearing the transmitter enable returns tx_o to 1 on the next cycle, abandoning any frame in flight, and the transmit-empty flag (status bit 5) keeps its value.
- R12: rts_o follows control bit 4 one cycle after the write and affects no other flag or output.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| mp_fmt | input | 1 | Multiprocessor framing select |
| baud_tick | input | 1 | 16x oversampling tick |
| reg_wr | input | 1 | Register write strobe |
| reg_rd | input | 1 | Register read strobe (read side effects) |
| reg_addr | input | 2 | 0 control, 1 status, 2 transmit data, 3 receive data |
| reg_wdata | input | 8 | Write data |
| reg_rdata | output | 8 | Read data for reg_addr, combinational |
| rx_i | input | 1 | Serial receive line |
| tx_o | output | 1 | Serial transmit line |
| rts_o | output | 1 | Request-to-send output |

## Verification
Random frames vary the data, the format bits, the framing select, the wake-up enable and the extra bit. Each combination of framing select and wake-up enable, paired with extra bit 0 or 1, shows whether the filter blocks or passes. The filter is the only thing that tells R4, R5 and R6 apart. Injected bad stop bits and flipped parity bits separate framing errors from parity errors, and they show that a blocked frame raises neither. Directed cases cover back-to-back frames without a read (overrun), an all-zero frame (break), a disabled receiver, a transmit abandoned with a second byte pending, and the request-to-send bit.

// File: rtl/mpuart_pkg.sv
package mpuart_pkg;

  localparam logic [1:0] ADDR_CTRL = 2'd0;
  localparam logic [1:0] ADDR_STAT = 2'd1;
  localparam logic [1:0] ADDR_TXD  = 2'd2;
  localparam logic [1:0] ADDR_RXD  = 2'd3;

  typedef struct packed {
    logic       wake_en;
    logic       rx_en;
    logic       tx_en;
    logic       rts;
    logic [2:0] fmt;   // [2] eight data bits, [1] parity on, [0] two stops
  } ctrl_t;

  function automatic logic [3:0] data_bits(logic [2:0] fmt);
    return fmt[2] ? 4'd8 : 4'd7;
  endfunction

  function automatic logic has_extra(logic [2:0] fmt, logic mp);
    return mp | fmt[1];
  endfunction

  // bits captured after the start bit: data, extra, first stop
  function automatic logic [3:0] rx_span(logic [2:0] fmt, logic mp);
    return data_bits(fmt) + {3'd0, has_extra(fmt, mp)} + 4'd1;
  endfunction

  // total bit slots in a transmitted frame
  function automatic logic [3:0] tx_span(logic [2:0] fmt, logic mp);
    return 4'd1 + data_bits(fmt) + {3'd0, has_extra(fmt, mp)} +
           (fmt[0] ? 4'd2 : 4'd1);
  endfunction

  function automatic logic even_par(logic [7:0] d, logic [2:0] fmt);
    return fmt[2] ? ^d : ^d[6:0];
  endfunction

  function automatic logic [11:0] build_frame(logic [7:0] d, logic [2:0] fmt,
                                              logic mp, logic mpb);
    logic [11:0] f;
    logic [3:0]  nd;
    f    = '1;
    f[0] = 1'b0;
    nd   = data_bits(fmt);
    for (int i = 0; i < 8; i++)
      if (i < int'(nd)) f[i+1] = d[i];
    if (has_extra(fmt, mp))
      f[nd + 4'd1] = mp ? mpb : even_par(d, fmt);
    return f;
  endfunction

endpackage

// File: rtl/mpuart_tx.sv
module mpuart_tx
  import mpuart_pkg::*;
#(
  parameter int OVS = 16
) (
  input  logic       clk,
  input  logic       rst_n,
  input  logic       tick,
  input  logic       en,
  input  logic [2:0] fmt,
  input  logic       mp,
  input  logic       mpb_in,
  input  logic       wr,
  input  logic [7:0] wdata,
  output logic       tx_o,
  output logic       tdre,
  output logic       busy
);
  localparam int CW = $clog2(OVS);
  localparam logic [CW-1:0] LAST = CW'(OVS - 1);

  logic [7:0]    hold;
  logic [11:0]   shreg;
  logic [3:0]    left;
  logic [CW-1:0] sub;
  logic          load_evt;

  assign load_evt = en && !busy && !tdre;
  assign tx_o     = busy ? shreg[0] : 1'b1;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      hold  <= '0;
      shreg <= '1;
      left  <= '0;
      sub   <= '0;
      busy  <= 1'b0;
      tdre  <= 1'b1;
    end else begin
      if (wr) hold <= wdata;
      if (wr) tdre <= 1'b0;
      else if (load_evt) tdre <= 1'b1;
      if (!en) begin
        busy <= 1'b0;
      end else if (load_evt) begin
        shreg <= build_frame(hold, fmt, mp, mpb_in);
        left  <= tx_span(fmt, mp);
        sub   <= '0;
        busy  <= 1'b1;
      end else if (busy && tick) begin
        if (sub == LAST) begin
          sub   <= '0;
          shreg <= {1'b1, shreg[11:1]};
          left  <= left - 4'd1;
          if (left == 4'd1) busy <= 1'b0;
        end else begin
          sub <= sub + 1'b1;
        end
      end
    end
  end

  AST_TX_ABORT_IDLE: assert property (@(posedge clk) disable iff (!rst_n)
    !en |=> tx_o); // R11
  AST_TDRE_HELD: assert property (@(posedge clk) disable iff (!rst_n)
    (!en && !wr) |=> $stable(tdre)); // R11

endmodule

// File: rtl/mpuart_rx.sv
module mpuart_rx
  import mpuart_pkg::*;
#(
  parameter int OVS  = 16,
  parameter int SYNC = 2
) (
  input  logic       clk,
  input  logic       rst_n,
  input  logic       tick,
  input  logic       en,
  input  logic [2:0] fmt,
  input  logic       mp,
  input  logic       rx_i,
  output logic       done,
  output logic [7:0] data,
  output logic       extra,
  output logic       stop
);
  localparam int CW = $clog2(OVS);
  localparam logic [CW-1:0] LAST = CW'(OVS - 1);
  localparam logic [CW-1:0] MID  = CW'(OVS / 2 - 1);

  typedef enum logic [1:0] {RX_IDLE, RX_START, RX_BITS, RX_WAIT} rx_state_t;

  rx_state_t     state;
  logic [SYNC-1:0] sy;
  logic          rx_s;
  logic [CW-1:0] cnt;
  logic [3:0]    bidx;
  logic [9:0]    sh;
  logic [3:0]    nd;
  logic          ext_on;

  assign rx_s   = sy[SYNC-1];
  assign nd     = data_bits(fmt);
  assign ext_on = has_extra(fmt, mp);
  assign data   = fmt[2] ? sh[7:0] : {1'b0, sh[6:0]};
  assign extra  = ext_on ? sh[nd] : 1'b0;
  assign stop   = sh[nd + {3'd0, ext_on}];

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      sy    <= '1;
      state <= RX_IDLE;
      cnt   <= '0;
      bidx  <= '0;
      sh    <= '0;
      done  <= 1'b0;
    end else begin
      sy   <= {sy[SYNC-2:0], rx_i};
      done <= 1'b0;
      if (!en) begin
        state <= RX_IDLE;
      end else begin
        case (state)
          RX_IDLE: if (!rx_s) begin
            state <= RX_START;
            cnt   <= '0;
          end
          RX_START: if (tick) begin
            if (cnt == MID) begin
              cnt   <= '0;
              bidx  <= '0;
              state <= rx_s ? RX_IDLE : RX_BITS;
            end else cnt <= cnt + 1'b1;
          end
          RX_BITS: if (tick) begin
            if (cnt == LAST) begin
              cnt      <= '0;
              sh[bidx] <= rx_s;
              if (bidx == rx_span(fmt, mp) - 4'd1) begin
                done  <= 1'b1;
                state <= RX_WAIT;
              end else bidx <= bidx + 4'd1;
            end else cnt <= cnt + 1'b1;
          end
          default: if (rx_s) state <= RX_IDLE;
        endcase
      end
    end
  end

  AST_RX_DONE_PULSE: assert property (@(posedge clk) disable iff (!rst_n)
    done |=> !done); // R3

endmodule

// File: rtl/mpuart_wake_flags.sv
module mpuart_wake_flags
  import mpuart_pkg::*;
(
  input  logic       clk,
  input  logic       rst_n,
  input  logic       done,
  input  logic [7:0] data,
  input  logic       extra,
  input  logic       stop,
  input  logic [2:0] fmt,
  input  logic       mp,
  input  logic       wake_en,
  input  logic       rd_clr,
  input  logic       err_clr,
  output logic       rdrf,
  output logic [7:0] rdr,
  output logic       ovr,
  output logic       fe,
  output logic       pe,
  output logic       brk,
  output logic       last_mpb
);
  logic accept;
  logic take;
  logic fe_evt, pe_evt, brk_evt;

  assign accept  = !mp || !wake_en || extra;
  assign take    = done && accept;
  assign fe_evt  = !stop;
  assign pe_evt  = !mp && fmt[1] && (extra != even_par(data, fmt));
  assign brk_evt = !stop && (data == 8'd0) && !extra;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      rdrf     <= 1'b0;
      rdr      <= '0;
      ovr      <= 1'b0;
      fe       <= 1'b0;
      pe       <= 1'b0;
      brk      <= 1'b0;
      last_mpb <= 1'b0;
    end else begin
      if (rd_clr) rdrf <= 1'b0;
      if (err_clr) begin
        ovr <= 1'b0;
        fe  <= 1'b0;
        pe  <= 1'b0;
        brk <= 1'b0;
      end
      if (done && mp) last_mpb <= extra;
      if (take) begin
        if (rdrf && !rd_clr) begin
          ovr <= 1'b1;
        end else begin
          rdr  <= data;
          rdrf <= 1'b1;
        end
        if (fe_evt)  fe  <= 1'b1;
        if (pe_evt)  pe  <= 1'b1;
        if (brk_evt) brk <= 1'b1;
      end
    end
  end

  AST_WAKE_BLOCK: assert property (@(posedge clk) disable iff (!rst_n)
    (done && mp && wake_en && !extra && !rd_clr && !err_clr)
      |=> ($stable(rdrf) && $stable(rdr) && $stable({ovr, fe, pe, brk}))); // R5
  AST_MP_OFF_ACCEPT: assert property (@(posedge clk) disable iff (!rst_n)
    (done && !mp) |=> rdrf); // R4
  AST_OVERRUN_SET: assert property (@(posedge clk) disable iff (!rst_n)
    (take && rdrf && !rd_clr) |=> (ovr && $stable(rdr))); // R10
  AST_ERR_CLEAR: assert property (@(posedge clk) disable iff (!rst_n)
    (err_clr && !done) |=> !(ovr || fe || pe || brk)); // R8

endmodule

// File: rtl/mpuart_chan.sv
module mpuart_chan
  import mpuart_pkg::*;
#(
  parameter int OVS  = 16,
  parameter int SYNC = 2
) (
  input  logic       clk,
  input  logic       rst_n,
  input  logic       mp_fmt,
  input  logic       baud_tick,
  input  logic       reg_wr,
  input  logic       reg_rd,
  input  logic [1:0] reg_addr,
  input  logic [7:0] reg_wdata,
  output logic [7:0] reg_rdata,
  input  logic       rx_i,
  output logic       tx_o,
  output logic       rts_o
);
  ctrl_t      ctrl;
  logic       tx_mpb;
  logic       wr_ctrl, wr_stat, wr_txd, rd_rxd, err_clr;
  logic       tdre, tx_busy;
  logic       rx_done, rx_extra, rx_stop;
  logic [7:0] rx_data;
  logic       rdrf, ovr, fe, pe, brk, last_mpb;
  logic [7:0] rdr;

  assign wr_ctrl = reg_wr && (reg_addr == ADDR_CTRL);
  assign wr_stat = reg_wr && (reg_addr == ADDR_STAT);
  assign wr_txd  = reg_wr && (reg_addr == ADDR_TXD);
  assign rd_rxd  = reg_rd && (reg_addr == ADDR_RXD);
  assign err_clr = wr_ctrl && !reg_wdata[3];
  assign rts_o   = ctrl.rts;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      ctrl   <= '0;
      tx_mpb <= 1'b0;
    end else begin
      if (wr_ctrl) ctrl <= ctrl_t'({reg_wdata[7:4], reg_wdata[2:0]});
      if (wr_stat) tx_mpb <= reg_wdata[7];
    end
  end

  always_comb begin
    case (reg_addr)
      ADDR_CTRL: reg_rdata = {ctrl.wake_en, ctrl.rx_en, ctrl.tx_en, ctrl.rts,
                              mp_fmt & last_mpb, ctrl.fmt};
      ADDR_STAT: reg_rdata = {tx_mpb, rdrf, tdre, ovr, fe, pe, brk, 1'b0};
      ADDR_RXD:  reg_rdata = rdr;
      default:   reg_rdata = 8'd0;
    endcase
  end

  mpuart_tx #(.OVS(OVS)) tx_i (
    .clk(clk), .rst_n(rst_n), .tick(baud_tick), .en(ctrl.tx_en),
    .fmt(ctrl.fmt), .mp(mp_fmt), .mpb_in(tx_mpb), .wr(wr_txd),
    .wdata(reg_wdata), .tx_o(tx_o), .tdre(tdre), .busy(tx_busy)
  );

  mpuart_rx #(.OVS(OVS), .SYNC(SYNC)) rx_u (
    .clk(clk), .rst_n(rst_n), .tick(baud_tick), .en(ctrl.rx_en),
    .fmt(ctrl.fmt), .mp(mp_fmt), .rx_i(rx_i), .done(rx_done),
    .data(rx_data), .extra(rx_extra), .stop(rx_stop)
  );

  mpuart_wake_flags flags_u (
    .clk(clk), .rst_n(rst_n), .done(rx_done), .data(rx_data),
    .extra(rx_extra), .stop(rx_stop), .fmt(ctrl.fmt), .mp(mp_fmt),
    .wake_en(ctrl.wake_en), .rd_clr(rd_rxd), .err_clr(err_clr),
    .rdrf(rdrf), .rdr(rdr), .ovr(ovr), .fe(fe), .pe(pe), .brk(brk),
    .last_mpb(last_mpb)
  );

  AST_RTS_WRITE: assert property (@(posedge clk) disable iff (!rst_n)
    wr_ctrl |=> (rts_o == $past(reg_wdata[4]))); // R12
  AST_RX_OFF_QUIET: assert property (@(posedge clk) disable iff (!rst_n)
    (!ctrl.rx_en && $past(!ctrl.rx_en)) |-> !rx_done); // R3
  AST_BUSY_NEEDS_EN: assert property (@(posedge clk) disable iff (!rst_n)
    tx_busy |-> $past(ctrl.tx_en)); // R11

endmodule

// File: tb/mpuart_chan_tb.sv
module mpuart_chan_tb_top;
  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic       mp_fmt = 1'b0;
  logic       baud_tick = 1'b1;
  logic       reg_wr = 1'b0;
  logic       reg_rd = 1'b0;
  logic [1:0] reg_addr = 2'd0;
  logic [7:0] reg_wdata = 8'd0;
  logic [7:0] reg_rdata;
  logic       rx_i = 1'b1;
  logic       tx_o, rts_o;

  int checks = 0;
  int errors = 0;

  always #4 clk = ~clk;

  mpuart_chan dut_i (
    .clk(clk), .rst_n(rst_n), .mp_fmt(mp_fmt), .baud_tick(baud_tick),
    .reg_wr(reg_wr), .reg_rd(reg_rd), .reg_addr(reg_addr),
    .reg_wdata(reg_wdata), .reg_rdata(reg_rdata), .rx_i(rx_i),
    .tx_o(tx_o), .rts_o(rts_o)
  );

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s: actual %0h expected %0h", req, act, exp);
    end
  endtask

  task automatic wr(input logic [1:0] a, input logic [7:0] d);
    @(negedge clk);
    reg_wr = 1'b1; reg_addr = a; reg_wdata = d;
    @(negedge clk);
    reg_wr = 1'b0;
  endtask

  task automatic rd(input logic [1:0] a, output logic [7:0] d);
    @(negedge clk);
    reg_rd = 1'b1; reg_addr = a;
    #1 d = reg_rdata;
    @(negedge clk);
    reg_rd = 1'b0;
  endtask

  function automatic logic [7:0] ctl(logic we, logic re, logic te, logic rts,
                                     logic keep, logic [2:0] f);
    return {we, re, te, rts, keep, f};
  endfunction

  function automatic int nbits(logic [2:0] f);
    return f[2] ? 8 : 7;
  endfunction

  // bit list of a frame, LSB = first on the line; n returns its length
  function automatic logic [11:0] exp_frame(logic [7:0] d, logic [2:0] f,
                                            logic mp, logic mpb, output int n);
    logic [11:0] v;
    int p;
    logic par;
    v = '0; p = 1; par = 1'b0;
    for (int i = 0; i < nbits(f); i++) begin
      v[p] = d[i]; par = par ^ d[i]; p++;
    end
    if (mp) begin v[p] = mpb; p++; end
    else if (f[1]) begin v[p] = par; p++; end
    v[p] = 1'b1; p++;
    if (f[0]) begin v[p] = 1'b1; p++; end
    n = p;
    return v;
  endfunction

  task automatic drive_rx(input logic [11:0] v, input int n);
    for (int i = 0; i < n; i++) begin
      @(negedge clk); rx_i = v[i];
      repeat (15) @(negedge clk);
    end
    @(negedge clk); rx_i = 1'b1;
    repeat (40) @(negedge clk);
  endtask

  task automatic check_tx(input logic [7:0] d, input logic [2:0] f,
                          input logic mp, input logic mpb);
    logic [11:0] v;
    int n, w;
    v = exp_frame(d, f, mp, mpb, n);
    w = 0;
    while (tx_o === 1'b1 && w < 200) begin @(negedge clk); w++; end
    repeat (8) @(negedge clk);
    for (int i = 0; i < n; i++) begin
      chk("R2 tx bit", {31'd0, tx_o}, {31'd0, v[i]});
      repeat (16) @(negedge clk);
    end
  endtask

  logic [7:0] rv;

  initial begin : watchdog
    repeat (200000) @(posedge clk);
    errors++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin : main
    void'($urandom(32'h5A17));
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);

    // R1 reset state
    rd(2'd0, rv); chk("R1 ctrl", {24'd0, rv & 8'hF7}, 32'h00);
    rd(2'd1, rv); chk("R1 status", {24'd0, rv}, 32'h20);
    chk("R1 tx idle", {31'd0, tx_o}, 32'd1);
    chk("R1 rts", {31'd0, rts_o}, 32'd0);

    // R12 RTS bit
    wr(2'd0, ctl(0, 0, 0, 1, 1, 3'd0));
    chk("R12 rts high", {31'd0, rts_o}, 32'd1);
    rd(2'd1, rv); chk("R12 status untouched", {24'd0, rv}, 32'h20);
    chk("R12 tx untouched", {31'd0, tx_o}, 32'd1);
    wr(2'd0, ctl(0, 0, 0, 0, 1, 3'd0));
    chk("R12 rts low", {31'd0, rts_o}, 32'd0);

    // R2 transmit formats
    for (int k = 0; k < 8; k++) begin
      logic [2:0] f;
      logic mp, mpb;
      logic [7:0] d;
      f = k[2:0]; mp = ($urandom % 2) == 1; mpb = ($urandom % 2) == 1;
      d = 8'($urandom);
      mp_fmt = mp;
      wr(2'd1, {mpb, 7'd0});
      wr(2'd0, ctl(0, 0, 1, 0, 1, f));
      wr(2'd2, d);
      check_tx(d, f, mp, mpb);
      repeat (40) @(negedge clk);
      rd(2'd1, rv); chk("R2 tdre after frame", {31'd0, rv[5]}, 32'd1);
    end

    // R11 abort with a second byte pending
    mp_fmt = 1'b0;
    wr(2'd0, ctl(0, 0, 1, 0, 1, 3'b100));
    wr(2'd2, 8'hA5);
    repeat (30) @(negedge clk);
    wr(2'd2, 8'h3C);
    repeat (30) @(negedge clk);
    wr(2'd0, ctl(0, 0, 0, 0, 1, 3'b100));
    chk("R11 line idle after abort", {31'd0, tx_o}, 32'd1);
    rd(2'd1, rv); chk("R11 tdre held", {31'd0, rv[5]}, 32'd0);
    repeat (40) @(negedge clk);
    chk("R11 line stays idle", {31'd0, tx_o}, 32'd1);
    wr(2'd0, ctl(0, 0, 1, 0, 1, 3'b100));
    check_tx(8'h3C, 3'b100, 1'b0, 1'b0);
    repeat (40) @(negedge clk);
    wr(2'd0, ctl(0, 0, 0, 0, 0, 3'b100));

    // R3 receiver disabled ignores frames
    begin
      logic [11:0] v; int n;
      v = exp_frame(8'h5E, 3'b100, 1'b0, 1'b0, n);
      drive_rx(v, n);
      rd(2'd1, rv); chk("R3 rx disabled no rdrf", {31'd0, rv[6]}, 32'd0);
    end

    // R10 overrun, then R8 clear only on 0
    begin
      logic [11:0] v; int n;
      wr(2'd0, ctl(0, 1, 0, 0, 1, 3'b100));
      v = exp_frame(8'h11, 3'b100, 1'b0, 1'b0, n); drive_rx(v, n);
      v = exp_frame(8'h22, 3'b100, 1'b0, 1'b0, n); drive_rx(v, n);
      rd(2'd1, rv); chk("R10 overrun set", {31'd0, rv[4]}, 32'd1);
      rd(2'd3, rv); chk("R10 first data kept", {24'd0, rv}, 32'h11);
      rd(2'd1, rv); chk("R3 read clears rdrf", {31'd0, rv[6]}, 32'd0);
      wr(2'd0, ctl(0, 1, 0, 0, 1, 3'b100));
      rd(2'd1, rv); chk("R8 write 1 keeps overrun", {31'd0, rv[4]}, 32'd1);
      wr(2'd0, ctl(0, 1, 0, 0, 0, 3'b100));
      rd(2'd1, rv); chk("R8 write 0 clears", {24'd0, rv & 8'h1E}, 32'd0);
    end

    // R9 break frame
    begin
      drive_rx(12'd0, 10);
      rd(2'd1, rv); chk("R9 break flags", {24'd0, rv & 8'h5E}, 32'h4A);
      rd(2'd3, rv); chk("R9 break data", {24'd0, rv}, 32'h00);
      wr(2'd0, ctl(0, 1, 0, 0, 0, 3'b100));
    end

    // random receive: filter R4 R5 R6, errors R9, readback R7
    for (int it = 0; it < 48; it++) begin
      logic [2:0] f;
      logic mp, we, mpb, sbad, pflip, acc, hx;
      logic [7:0] d;
      logic [11:0] v;
      int n, sp;
      string tag;
      f = 3'($urandom); mp = ($urandom % 2) == 1; we = ($urandom % 2) == 1;
      mpb = ($urandom % 2) == 1;
      d = 8'($urandom);
      if (!f[2]) d[7] = 1'b0;
      if (it % 11 == 5) d = 8'd0;
      sbad = ($urandom % 6) == 0; pflip = ($urandom % 5) == 0;
      hx = mp || f[1];
      mp_fmt = mp;
      wr(2'd0, ctl(we, 1, 0, 0, 1, f));
      v = exp_frame(d, f, mp, mpb, n);
      sp = 1 + nbits(f) + (hx ? 1 : 0);
      if (pflip && hx && !mp) v[sp-1] = ~v[sp-1];
      if (sbad) v[sp] = 1'b0;
      if (it % 11 == 5 && sbad) v = '0;
      drive_rx(v, n);
      acc = !mp || !we || mpb;
      tag = !mp ? "R4" : (we ? "R5" : "R6");
      rd(2'd1, rv);
      chk({tag, " rdrf"}, {31'd0, rv[6]}, {31'd0, acc});
      chk({"R9 fe ", tag}, {31'd0, rv[3]}, {31'd0, acc && !v[sp]});
      chk({"R9 pe ", tag}, {31'd0, rv[2]},
          {31'd0, acc && !mp && f[1] && (v[sp-1] != ^d)});
      chk({"R9 brk ", tag}, {31'd0, rv[1]},
          {31'd0, acc && ((v & ((12'd1 << (sp + 1)) - 12'd1)) == 12'd0)});
      chk({tag, " no overrun"}, {31'd0, rv[4]}, 32'd0);
      if (acc) begin
        rd(2'd3, rv); chk({"R3 data ", tag}, {24'd0, rv}, {24'd0, d});
      end
      rd(2'd0, rv); chk("R7 readback", {31'd0, rv[3]}, {31'd0, mp && mpb});
      wr(2'd0, ctl(we, 1, 0, 0, 0, f));
      rd(2'd1, rv); chk("R8 clear", {24'd0, rv & 8'h5E}, 32'd0);
    end

    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule